// File: doc/BRIEF.md
# Raster Line and Frame Timing Generator

This block sets the pace of a raster video controller. A two-state machine splits every scanline into a drawing phase and a horizontal blanking phase. A line counter advances at the end of each blanking phase and wraps after the last line of the frame. From these the block derives three status flags: horizontal blank, vertical blank and line-compare match. It also raises one-cycle interrupt request pulses, each gated by its own enable bit. The pulses are meant to set latched bits in an interrupt controller outside the block. An external renderer uses the `draw_active` level to know when to fetch and emit pixels.

The phase machine has two states. `PH_DRAW` lasts `DRAW_CYC` cycles, and its transition `draw_done` leads to `PH_HBLANK`. `PH_HBLANK` lasts `HBLANK_CYC` cycles, and its transition `line_done` leads back to `PH_DRAW` and advances the line counter. Reset enters `PH_DRAW` at line 0. With the defaults, a line is 960 + 272 = 1232 cycles and a frame is 228 lines, of which lines 0 to 159 are visible.

Software sees two 16-bit registers. Address 0 is status and control. Address 1 is the line counter, which is read-only.

Top module: `raster_timing_gen`

## Requirements
- R1: A synchronous reset (`rst` high) gives the following state on release: line 0, `PH_DRAW` at its first cycle, all three flags clear, all enables clear, compare value 0, and no interrupt pulse.
- R2: Each line spends `DRAW_CYC` cycles in `PH_DRAW`, with `draw_active` high. It then spends `HBLANK_CYC` cycles in `PH_HBLANK`, with `draw_active` low. The horizontal-blank flag (status bit 1) is high exactly during `PH_HBLANK`.
- R3: The line counter (address 1, bits LINE_W-1:0, upper bits zero) increments on the `line_done` transition. It wraps from `TOTAL_LINES-1` to 0.
- R4: The vertical-blank flag (status bit 0) sets when the counter becomes `VISIBLE_LINES`.
- R5: The vertical-blank flag clears when the counter becomes `TOTAL_LINES-1`, one line before the wrap. It stays clear through line 0 and the visible lines.
- R6: On every counter advance, the match flag (status bit 2) takes the result of comparing the new line value with the compare value (status bits 15:8). It is 1 on equality and 0 otherwise. Between advances it holds, and it is clear from reset until the first advance.
- R7: On the `draw_done` transition of every line, blanking lines included, `irq_hblank` pulses if the horizontal-blank enable (status bit 4) is set.
- R8: `irq_vblank` pulses in the cycle the counter becomes `VISIBLE_LINES`, if the vertical-blank enable (status bit 3) is set.
- R9: `irq_match` pulses in the cycle an advance produces a match, if the match enable (status bit 5) is set. This includes a match on line 0 at the wrap.
- R10: Every interrupt pulse lasts exactly one cycle. No pulse appears while its enable is clear.
- R11: A write to address 0 stores bits 5:3 as the enables and bits 15:8 as the compare value. Writes to flag bits 2:0, to bits 7:6 and to address 1 have no effect. Bits 7:6 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status/control, 1 line counter |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| draw_active | output | 1 | High during the drawing phase |
| irq_hblank | output | 1 | Horizontal-blank request pulse |
| irq_vblank | output | 1 | Vertical-blank request pulse |
| irq_match | output | 1 | Line-compare match request pulse |

## Verification
The bench shrinks the timing to `DRAW_CYC`=6, `HBLANK_CYC`=4, `TOTAL_LINES`=12 and `VISIBLE_LINES`=8. One line is then 10 cycles and a frame is 120 cycles, so every configuration can run through two frame wraps. That window covers the vertical-blank set and clear lines, the early clear on the last line, the compare-at-wrap to line 0, and a compare on the final line. The same state machine and counter logic runs at the default 960/272/228/160 values.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;
    typedef enum logic {
        PH_DRAW   = 1'b0,
        PH_HBLANK = 1'b1
    } phase_e;

    localparam int REG_W    = 16;
    localparam int CMP_W    = 8;
    localparam int BIT_VB   = 0;
    localparam int BIT_HB   = 1;
    localparam int BIT_MT   = 2;
    localparam int BIT_VBEN = 3;
    localparam int BIT_HBEN = 4;
    localparam int BIT_MTEN = 5;
    localparam int CMP_LSB  = 8;
endpackage

// File: rtl/dtg_phase_fsm.sv
`timescale 1ns/1ps
module dtg_phase_fsm
    import dtg_pkg::*;
#(
    parameter int DRAW_CYC   = 960,
    parameter int HBLANK_CYC = 272
) (
    input  logic   clk,
    input  logic   rst,
    output phase_e phase,
    output logic   hb_pulse,
    output logic   line_done
);
    localparam int MAXC = (DRAW_CYC > HBLANK_CYC) ? DRAW_CYC : HBLANK_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] DRAW_LAST = CW'(DRAW_CYC - 1);
    localparam logic [CW-1:0] HB_LAST   = CW'(HBLANK_CYC - 1);

    phase_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          draw_done;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PH_DRAW;
            cnt_q    <= '0;
            hb_pulse <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            hb_pulse <= draw_done;
        end
    end

    // Next state and transition outputs
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q + 1'b1;
        draw_done = 1'b0;
        line_done = 1'b0;
        unique case (state_q)
            PH_DRAW: begin
                if (cnt_q == DRAW_LAST) begin
                    draw_done = 1'b1;
                    state_d   = PH_HBLANK;
                    cnt_d     = '0;
                end
            end
            PH_HBLANK: begin
                if (cnt_q == HB_LAST) begin
                    line_done = 1'b1;
                    state_d   = PH_DRAW;
                    cnt_d     = '0;
                end
            end
        endcase
    end

    assign phase = state_q;

    // R7
    hb_pulse_entry_chk: assert property (@(posedge clk) disable iff (rst)
        hb_pulse |-> (phase == PH_HBLANK && $past(phase) == PH_DRAW));

    // R2
    hb_leave_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(phase == PH_HBLANK) |-> $past(line_done));
endmodule

// File: rtl/dtg_line_ctr.sv
`timescale 1ns/1ps
module dtg_line_ctr
    import dtg_pkg::*;
#(
    parameter int TOTAL_LINES   = 228,
    parameter int VISIBLE_LINES = 160,
    parameter int LINE_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_done,
    input  logic [CMP_W-1:0]  cmp_val,
    output logic [LINE_W-1:0] line,
    output logic              vblank,
    output logic              match,
    output logic              vb_evt,
    output logic              match_evt
);
    localparam logic [LINE_W-1:0] LAST_L = LINE_W'(TOTAL_LINES - 1);
    localparam logic [LINE_W-1:0] VIS_L  = LINE_W'(VISIBLE_LINES);

    logic [LINE_W-1:0] next_line;
    logic              hit;

    always_comb begin
        next_line = (line == LAST_L) ? '0 : line + 1'b1;
        hit       = (32'(next_line) == 32'(cmp_val));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line      <= '0;
            vblank    <= 1'b0;
            match     <= 1'b0;
            vb_evt    <= 1'b0;
            match_evt <= 1'b0;
        end else begin
            vb_evt    <= line_done && (next_line == VIS_L);
            match_evt <= line_done && hit;
            if (line_done) begin
                line  <= next_line;
                match <= hit;
                if (next_line == VIS_L)
                    vblank <= 1'b1;
                else if (next_line == LAST_L)
                    vblank <= 1'b0;
            end
        end
    end

    // R3
    line_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(line) |-> $past(line_done));

    // R4
    vb_window_chk: assert property (@(posedge clk) disable iff (rst)
        (line >= VIS_L && line < LAST_L) |-> vblank);

    // R5
    vb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (line == LAST_L || line < VIS_L) |-> !vblank);

    // R6
    match_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(match) |-> $past(line_done));
endmodule

// File: rtl/dtg_regs.sv
`timescale 1ns/1ps
module dtg_regs
    import dtg_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              vblank,
    input  logic              hblank,
    input  logic              match,
    input  logic [LINE_W-1:0] line,
    output logic              en_vb,
    output logic              en_hb,
    output logic              en_mt,
    output logic [CMP_W-1:0]  cmp_val,
    output logic [REG_W-1:0]  rdata
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata[7:6], wdata[2:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_vb   <= 1'b0;
            en_hb   <= 1'b0;
            en_mt   <= 1'b0;
            cmp_val <= '0;
        end else if (wr && !addr) begin
            en_vb   <= wdata[BIT_VBEN];
            en_hb   <= wdata[BIT_HBEN];
            en_mt   <= wdata[BIT_MTEN];
            cmp_val <= wdata[CMP_LSB +: CMP_W];
        end
    end

    always_comb begin
        if (addr) begin
            rdata = REG_W'(line);
        end else begin
            rdata = '0;
            rdata[BIT_VB]               = vblank;
            rdata[BIT_HB]               = hblank;
            rdata[BIT_MT]               = match;
            rdata[BIT_VBEN]             = en_vb;
            rdata[BIT_HBEN]             = en_hb;
            rdata[BIT_MTEN]             = en_mt;
            rdata[CMP_LSB +: CMP_W]     = cmp_val;
        end
    end

    // R11
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!(wr && !addr)) |-> ($stable(cmp_val) && $stable(en_vb)
                                   && $stable(en_hb) && $stable(en_mt)));
endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
    import dtg_pkg::*;
#(
    parameter int DRAW_CYC      = 960,
    parameter int HBLANK_CYC    = 272,
    parameter int TOTAL_LINES   = 228,
    parameter int VISIBLE_LINES = 160
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        draw_active,
    output logic        irq_hblank,
    output logic        irq_vblank,
    output logic        irq_match
);
    localparam int LINE_W = $clog2(TOTAL_LINES);

    phase_e            phase;
    logic              hb_pulse, line_done;
    logic [LINE_W-1:0] line;
    logic              vblank, match, vb_evt, match_evt;
    logic              en_vb, en_hb, en_mt;
    logic [CMP_W-1:0]  cmp_val;
    logic              hblank;

    dtg_phase_fsm #(
        .DRAW_CYC   (DRAW_CYC),
        .HBLANK_CYC (HBLANK_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .hb_pulse  (hb_pulse),
        .line_done (line_done)
    );

    dtg_line_ctr #(
        .TOTAL_LINES   (TOTAL_LINES),
        .VISIBLE_LINES (VISIBLE_LINES),
        .LINE_W        (LINE_W)
    ) u_lines (
        .clk       (clk),
        .rst       (rst),
        .line_done (line_done),
        .cmp_val   (cmp_val),
        .line      (line),
        .vblank    (vblank),
        .match     (match),
        .vb_evt    (vb_evt),
        .match_evt (match_evt)
    );

    dtg_regs #(
        .LINE_W (LINE_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .vblank  (vblank),
        .hblank  (hblank),
        .match   (match),
        .line    (line),
        .en_vb   (en_vb),
        .en_hb   (en_hb),
        .en_mt   (en_mt),
        .cmp_val (cmp_val),
        .rdata   (reg_rdata)
    );

    // Output process
    always_comb begin
        hblank      = (phase == PH_HBLANK);
        draw_active = (phase == PH_DRAW);
        irq_hblank  = hb_pulse  && en_hb;
        irq_vblank  = vb_evt    && en_vb;
        irq_match   = match_evt && en_mt;
    end

    // R10
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_hblank || irq_vblank || irq_match) |=>
            !($past(irq_hblank) && irq_hblank) && !($past(irq_vblank) && irq_vblank)
            && !($past(irq_match) && irq_match));

    // R8
    irq_vb_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_vblank |-> (vblank && $rose(vblank)));

    // R9
    irq_mt_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_match |-> match);
endmodule

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
    localparam int DRAW  = 6;
    localparam int HB    = 4;
    localparam int TOTAL = 12;
    localparam int VIS   = 8;
    localparam int LCYC  = DRAW + HB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        draw_active, irq_hblank, irq_vblank, irq_match;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    raster_timing_gen #(
        .DRAW_CYC      (DRAW),
        .HBLANK_CYC    (HB),
        .TOTAL_LINES   (TOTAL),
        .VISIBLE_LINES (VIS)
    ) u_raster_timing_gen (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .draw_active (draw_active),
        .irq_hblank  (irq_hblank),
        .irq_vblank  (irq_vblank),
        .irq_match   (irq_match)
    );

    // Checkpoints: cycle since reset release, line, hblank, vblank
    localparam int NPT = 12;
    localparam int PTS [NPT][4] = '{
        '{0, 0, 0, 0},  '{5, 0, 0, 0},   '{6, 0, 1, 0},   '{9, 0, 1, 0},
        '{10, 1, 0, 0}, '{79, 7, 1, 0},  '{80, 8, 0, 1},  '{109, 10, 1, 1},
        '{110, 11, 0, 0}, '{116, 11, 1, 0}, '{120, 0, 0, 0}, '{126, 0, 1, 0}
    };

    // Configurations: enables {match, hblank, vblank}, compare value
    localparam int NCFG = 5;
    localparam int CFG [NCFG][2] = '{
        '{7, 3}, '{7, 0}, '{5, 11}, '{2, 8}, '{0, 8}
    };

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic read_regs(output logic [15:0] st, output logic [15:0] ln);
        reg_addr = 1'b0;
        #0.5 st = reg_rdata;
        reg_addr = 1'b1;
        #0.5 ln = reg_rdata;
        reg_addr = 1'b0;
    endtask

    task automatic write_reg(logic a, logic [15:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_addr = 1'b0;
    endtask

    task automatic full_check(int t, int en, int cmpv);
        logic [15:0] st, ln;
        int pos, lnum, e_vb, e_mt, first;
        pos   = t % LCYC;
        lnum  = (t / LCYC) % TOTAL;
        first = (t > 0 && pos == 0) ? 1 : 0;
        e_vb  = (lnum >= VIS && lnum < TOTAL - 1) ? 1 : 0;
        e_mt  = (t >= LCYC && lnum == cmpv) ? 1 : 0;
        read_regs(st, ln);
        check("R3", "line", int'(ln), lnum);
        check("R2", "hblank flag", int'(st[1]), (pos >= DRAW) ? 1 : 0);
        check("R2", "draw_active", int'(draw_active), (pos < DRAW) ? 1 : 0);
        check((lnum == TOTAL - 1) ? "R5" : "R4", "vblank flag", int'(st[0]), e_vb);
        check("R6", "match flag", int'(st[2]), e_mt);
        check("R7", "irq_hblank", int'(irq_hblank), (pos == DRAW && en[1]) ? 1 : 0);
        check("R8", "irq_vblank", int'(irq_vblank), (first == 1 && lnum == VIS && en[0]) ? 1 : 0);
        check("R9", "irq_match", int'(irq_match), (first == 1 && lnum == cmpv && en[2]) ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] st, ln;
        int t;

        // Checkpoint walk, nothing enabled
        do_reset();
        t = 0;
        for (int i = 0; i < NPT; i++) begin
            while (t < PTS[i][0]) begin
                @(negedge clk);
                t++;
            end
            read_regs(st, ln);
            check("R3", "line at checkpoint", int'(ln), PTS[i][1]);
            check("R2", "hblank at checkpoint", int'(st[1]), PTS[i][2]);
            check("R4", "vblank at checkpoint", int'(st[0]), PTS[i][3]);
            check("R10", "no irq when disabled", int'({irq_hblank, irq_vblank, irq_match}), 0);
        end

        // Configuration sweep over two frame wraps
        for (int c = 0; c < NCFG; c++) begin
            do_reset();
            read_regs(st, ln);
            check("R1", "status after reset", int'(st), 0);
            check("R1", "line after reset", int'(ln), 0);
            check("R1", "draw_active after reset", int'(draw_active), 1);
            check("R1", "irqs after reset", int'({irq_hblank, irq_vblank, irq_match}), 0);
            // flag bits and bits 7:6 written high must not stick
            write_reg(1'b0, {8'(CFG[c][1]), 2'b11, 3'(CFG[c][0]), 3'b111});
            read_regs(st, ln);
            check("R11", "compare field", int'(st[15:8]), CFG[c][1]);
            check("R11", "enable field", int'(st[5:3]), CFG[c][0]);
            check("R11", "flags and spare read-only", int'({st[7:6], st[2:0]}), 0);
            for (int t2 = 1; t2 < 250; t2++) begin
                full_check(t2, CFG[c][0], CFG[c][1]);
                @(negedge clk);
            end
        end

        // Write to the line register is ignored
        do_reset();
        write_reg(1'b1, 16'h0005);
        read_regs(st, ln);
        check("R11", "line write ignored", int'(ln), 0);
        check("R11", "line write leaves control", int'(st), 0);

        // Mid-line enable then reset clears it
        write_reg(1'b0, 16'h0738);
        do_reset();
        read_regs(st, ln);
        check("R1", "reset clears control", int'(st), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule